// File: doc/BRIEF.md
# One-Hot Transmitter Power Level Selector

This block holds the transmitter's selected power level as a one-hot register, one bit per level, with bit 0 as the lowest level. Each level has an active-low request input. The inputs reach the block already isolated and synchronized. A request loads its own bit and clears every other bit. When two or more requests arrive in the same cycle, the highest-indexed one is taken. The one-hot vector drives the level indicators, the enables for the level setpoints and the remote status lines.

For automatic cutback, a mode input disables the request path and turns the register into a shift chain. Each step pulse then moves the active level one place lower, and the chain stops at the lowest level. Whenever any level is held, the block raises a start request for the contactor logic. Together with the start request it raises a PDM kill, so that the high-voltage supply carries no load during step start. The kill stays up until the run-contactor auxiliary input reports closure. A mirror of the kill drives its indicator.

All ports are plain control and status pins. No data stream passes through the block, so it has no valid/ready handshake and no back-pressure.

Top module: `pwr_level_sel`

## Requirements
- R1: Outside cutback mode, a low on `lvl_req_n[i]` sets `level[i]` on the next rising clock edge.
- R2: Setting a level clears all other level bits. `level` never has more than one bit set.
- R3: If several request bits are low in the same cycle, only the highest index among them is loaded.
- R4: While `cutback_en` is high, the request inputs have no effect. A high `cutback_step` moves the set bit from index i to index i-1 on the next edge.
- R5: A cutback step taken while `level[0]` is set leaves `level[0]` set.
- R6: While `cutback_en` is low, `cutback_step` has no effect.
- R7: `start_req` is high exactly when some bit of `level` is set.
- R8: `pdm_kill` is high whenever `start_req` is high and run closure has not yet been confirmed. This includes the first cycle in which `start_req` rises.
- R9: A high `run_closed`, sampled at an edge while a level is held, drops `pdm_kill` from that edge on. The kill then stays low, whatever `run_closed` does, until the level register is cleared.
- R10: A high `rst` at a rising edge clears `level`, which also clears `start_req`, `pdm_kill` and the run confirmation.
- R11: `kill_led` always equals `pdm_kill`.
- R12: Outside cutback mode, with all request bits high, `level` holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| lvl_req_n | input | NUM_LEVELS | Active-low level requests, bit 0 = lowest level |
| cutback_en | input | 1 | Cutback mode: requests ignored, register shifts |
| cutback_step | input | 1 | One-cycle pulse that moves the level down one place in cutback mode |
| run_closed | input | 1 | Run-contactor auxiliary contact, high = closed |
| level | output | NUM_LEVELS | One-hot selected level |
| start_req | output | 1 | Start contactor request |
| pdm_kill | output | 1 | Modulator kill during step start |
| kill_led | output | 1 | Indicator mirror of the kill |

## Verification
The selector is driven with three kinds of requests: single requests at every index, simultaneous pairs and triples, and cycles with no request at all. Together these separate a correct exclusive load from a design that ORs bits together, picks the wrong priority or drifts while idle. In cutback mode, stray requests and repeated steps are applied, and the steps continue past the lowest level. This tells a proper shift apart from one that accepts requests, wraps around or empties the register. The run input is raised, dropped again and raised at the moment of a request. This shows whether the kill rises together with the start, whether it latches its release, and whether a reset rearms it.

// File: rtl/pl_pkg.sv
package pl_pkg;
  typedef enum logic [1:0] {
    SEQ_OFF  = 2'd0,
    SEQ_STEP = 2'd1,
    SEQ_RUN  = 2'd2
  } seq_state_t;
endpackage

// File: rtl/pl_req_pick.sv
module pl_req_pick #(
  parameter int NUM_LEVELS = 6
) (
  input  logic [NUM_LEVELS-1:0] req_n,
  output logic                  hit,
  output logic [NUM_LEVELS-1:0] pick
);
  logic [NUM_LEVELS-1:0] req;

  assign req = ~req_n;
  assign hit = |req;

  // The scan runs upward, so the highest active index is the last one written.
  always_comb begin
    pick = '0;
    for (int i = 0; i < NUM_LEVELS; i++) begin
      if (req[i]) begin
        pick    = '0;
        pick[i] = 1'b1;
      end
    end
  end
endmodule

// File: rtl/pl_level_reg.sv
module pl_level_reg #(
  parameter int NUM_LEVELS = 6
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  cutback_en,
  input  logic                  cutback_step,
  input  logic                  req_hit,
  input  logic [NUM_LEVELS-1:0] req_pick,
  output logic [NUM_LEVELS-1:0] level_q
);
  logic [NUM_LEVELS-1:0] shifted;
  logic [NUM_LEVELS-1:0] level_d;

  generate
    for (genvar g = 0; g < NUM_LEVELS; g++) begin : g_shift
      if (g == 0) begin : g_floor
        assign shifted[g] = level_q[0] | ((NUM_LEVELS > 1) ? level_q[1 % NUM_LEVELS] : 1'b0);
      end else if (g == NUM_LEVELS - 1) begin : g_top
        assign shifted[g] = 1'b0;
      end else begin : g_mid
        assign shifted[g] = level_q[g+1];
      end
    end
  endgenerate

  always_comb begin
    level_d = level_q;
    if (cutback_en) begin
      if (cutback_step) level_d = shifted;
    end else if (req_hit) begin
      level_d = req_pick;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) level_q <= '0;
    else     level_q <= level_d;
  end

  // R2
  onehot_level_chk: assert property (@(posedge clk) disable iff (rst) $onehot0(level_q));

  // R4
  cutback_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (cutback_en && !cutback_step) |=> $stable(level_q));

  // R5
  floor_sat_chk: assert property (@(posedge clk) disable iff (rst)
    (cutback_en && cutback_step && level_q[0]) |=> level_q[0]);

  // R12
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!cutback_en && req_pick == '0) |=> $stable(level_q));

  // R10
  reset_clear_chk: assert property (@(posedge clk) rst |=> (level_q == '0));
endmodule

// File: rtl/pl_start_seq.sv
module pl_start_seq
  import pl_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic any_level,
  input  logic run_closed,
  output logic start_req,
  output logic pdm_kill
);
  seq_state_t st_q, st_d;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      SEQ_OFF:  if (any_level) st_d = run_closed ? SEQ_RUN : SEQ_STEP;
      SEQ_STEP: if (!any_level) st_d = SEQ_OFF;
                else if (run_closed) st_d = SEQ_RUN;
      SEQ_RUN:  if (!any_level) st_d = SEQ_OFF;
      default:  st_d = SEQ_OFF;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) st_q <= SEQ_OFF;
    else     st_q <= st_d;
  end

  assign start_req = any_level;
  assign pdm_kill  = any_level && (st_q != SEQ_RUN);

  // R8
  kill_with_start_chk: assert property (@(posedge clk) disable iff (rst)
    pdm_kill |-> start_req);

  // R9
  kill_release_chk: assert property (@(posedge clk) disable iff (rst)
    (pdm_kill && run_closed) |=> !pdm_kill);

  // R9
  run_latched_chk: assert property (@(posedge clk) disable iff (rst)
    (start_req && !pdm_kill) |=> !pdm_kill);
endmodule

// File: rtl/pwr_level_sel.sv
module pwr_level_sel #(
  parameter int NUM_LEVELS = 6
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [NUM_LEVELS-1:0] lvl_req_n,
  input  logic                  cutback_en,
  input  logic                  cutback_step,
  input  logic                  run_closed,
  output logic [NUM_LEVELS-1:0] level,
  output logic                  start_req,
  output logic                  pdm_kill,
  output logic                  kill_led
);
  logic                  req_hit;
  logic [NUM_LEVELS-1:0] req_pick;
  logic                  any_level;

  pl_req_pick #(.NUM_LEVELS(NUM_LEVELS)) u_pick (
    .req_n (lvl_req_n),
    .hit   (req_hit),
    .pick  (req_pick)
  );

  pl_level_reg #(.NUM_LEVELS(NUM_LEVELS)) u_reg (
    .clk          (clk),
    .rst          (rst),
    .cutback_en   (cutback_en),
    .cutback_step (cutback_step),
    .req_hit      (req_hit),
    .req_pick     (req_pick),
    .level_q      (level)
  );

  assign any_level = |level;

  pl_start_seq u_seq (
    .clk        (clk),
    .rst        (rst),
    .any_level  (any_level),
    .run_closed (run_closed),
    .start_req  (start_req),
    .pdm_kill   (pdm_kill)
  );

  assign kill_led = pdm_kill;

  // R11
  led_mirror_chk: assert property (@(posedge clk) disable iff (rst) kill_led == pdm_kill);

  // R7
  start_track_chk: assert property (@(posedge clk) disable iff (rst) start_req == (level != '0));
endmodule

// File: tb/test_pwr_level_sel.sv
module test_pwr_level_sel;
  localparam int CLK_PERIOD = 10;
  localparam int N = 6;

  logic         clk = 1'b0;
  logic         rst;
  logic [N-1:0] lvl_req_n;
  logic         cutback_en, cutback_step, run_closed;
  logic [N-1:0] level;
  logic         start_req, pdm_kill, kill_led;

  int    n_tests = 0;
  int    n_fail  = 0;
  int    ref_lvl = -1;
  bit    ref_run = 1'b0;
  bit    checking = 1'b0;
  string cur_tag  = "R10";
  string kill_tag = "R8";

  always #(CLK_PERIOD/2) clk = ~clk;

  pwr_level_sel #(.NUM_LEVELS(N)) i_pwr_level_sel (
    .clk(clk), .rst(rst), .lvl_req_n(lvl_req_n), .cutback_en(cutback_en),
    .cutback_step(cutback_step), .run_closed(run_closed), .level(level),
    .start_req(start_req), .pdm_kill(pdm_kill), .kill_led(kill_led)
  );

  // Behavioural reference: an integer level index and a run-confirmed flag
  always @(posedge clk) begin
    int old_lvl;
    old_lvl = ref_lvl;
    if (rst) begin
      ref_lvl = -1;
      ref_run = 1'b0;
    end else begin
      if (cutback_en) begin
        if (cutback_step && ref_lvl > 0) ref_lvl = ref_lvl - 1;
      end else begin
        for (int i = 0; i < N; i++) if (lvl_req_n[i] == 1'b0) ref_lvl = i;
      end
      if (old_lvl < 0) ref_run = 1'b0;
      else if (run_closed) ref_run = 1'b1;
    end
  end

  task automatic check1(string tag, string what, int act, int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (checking) begin
      int  exp_level;
      bit  exp_start, exp_kill;
      exp_level = (ref_lvl < 0) ? 0 : (1 << ref_lvl);
      exp_start = (ref_lvl >= 0);
      exp_kill  = exp_start && !ref_run;
      check1(cur_tag, "level", int'(level), exp_level);
      check1("R7", "start_req", int'(start_req), int'(exp_start));
      check1(kill_tag, "pdm_kill", int'(pdm_kill), int'(exp_kill));
      check1("R11", "kill_led", int'(kill_led), int'(exp_kill));
    end
  end

  task automatic cycles(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    rst = 1'b1; lvl_req_n = '1; cutback_en = 1'b0; cutback_step = 1'b0; run_closed = 1'b0;
    @(negedge clk);
    checking = 1'b1;
    cur_tag = "R10";
    cycles(2);
    rst = 1'b0;
    cur_tag = "R12";
    cycles(3);
    // R1: each level on its own
    cur_tag = "R1";
    for (int i = 0; i < N; i++) begin
      lvl_req_n = ~(6'b1 << i);
      cycles(1);
      lvl_req_n = '1;
      cycles(1);
    end
    // R3: simultaneous requests
    cur_tag = "R3";
    lvl_req_n = ~6'b010010; cycles(2);
    lvl_req_n = ~6'b100101; cycles(1);
    lvl_req_n = ~6'b000011; cycles(1);
    lvl_req_n = '1;
    cur_tag = "R12";
    cycles(2);
    // R9: run closure releases the kill and latches
    kill_tag = "R9";
    run_closed = 1'b1; cycles(2);
    run_closed = 1'b0; cycles(1);
    cur_tag = "R2";
    lvl_req_n = ~6'b000100; cycles(1);
    lvl_req_n = ~6'b001000; cycles(1);
    lvl_req_n = '1; cycles(1);
    // R4: cutback mode ignores requests and shifts
    cur_tag = "R4";
    cutback_en = 1'b1;
    lvl_req_n = ~6'b100000; cycles(2);
    lvl_req_n = '1;
    for (int k = 0; k < 3; k++) begin
      cutback_step = 1'b1; cycles(1);
      cutback_step = 1'b0; cycles(1);
    end
    // R5: saturation at the lowest level
    cur_tag = "R5";
    cutback_step = 1'b1; cycles(4);
    cutback_step = 1'b0; cycles(1);
    // R6: step has no effect outside cutback
    cur_tag = "R6";
    cutback_en = 1'b0;
    lvl_req_n = ~6'b010000; cycles(1);
    lvl_req_n = '1;
    cutback_step = 1'b1; cycles(3);
    cutback_step = 1'b0;
    // R10: reset mid-run, then a fresh start holds the kill
    cur_tag = "R10";
    rst = 1'b1; cycles(1);
    rst = 1'b0; cycles(1);
    kill_tag = "R8";
    cur_tag = "R1";
    lvl_req_n = ~6'b000100; cycles(1);
    lvl_req_n = '1; cycles(3);
    kill_tag = "R9";
    run_closed = 1'b1; cycles(2);
    run_closed = 1'b0; cycles(2);
    // R8: run already closed at the moment of a request after reset
    rst = 1'b1; cycles(1);
    rst = 1'b0;
    kill_tag = "R8";
    run_closed = 1'b1;
    lvl_req_n = ~6'b000001; cycles(1);
    lvl_req_n = '1; cycles(3);
    checking = 1'b0;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule